// File: doc/BRIEF.md
# Dispersion Tree Split Node

One stage of an outward tree that moves traffic from a cache bank toward a row of cores. A single upstream link feeds the node. Flits on that link belong to one of two classes, each with its own virtual channel and buffer: data responses and snoop requests. Each cycle the node picks at most one buffered flit. It sends that flit either out of the local exit to the core attached at this position, or onward through the network output to the next node farther from the bank.

A flit is `DEST_W+PAY_W+2` bits wide. Bit `[DEST_W+PAY_W+1]` marks the first flit of a packet and bit `[DEST_W+PAY_W]` marks the last. Bits `[DEST_W+PAY_W-1:PAY_W]` carry the destination core index and the low `PAY_W` bits carry the payload. Class code 0 is a data response and code 1 is a snoop request. In every two-bit credit vector, bit 0 belongs to the response class and bit 1 to the snoop class. The upstream sender may place a flit in a class only while it holds a credit for that class. The node returns one credit for each flit that leaves.

Top module: `dsn_split_node`

## Requirements
- R1: During reset and in the first cycle after it, no output is valid and no upstream credit is raised. Each per-output, per-class credit counter starts at `DN_CREDITS`.
- R2: A first flit whose destination field equals `NODE_ID` leaves on the local exit. Any other destination sends it to the network output. The class code and all flit bits are unchanged.
- R3: Every later flit of a packet, up to and including the last one, takes the same output as the first flit of that packet, whatever its own destination field holds. A flit that is not first and arrives outside an open packet is steered by its own destination field.
- R4: When a flit arrives at an empty node whose chosen output has credit, it is presented on that output in the clock cycle that follows its arrival edge.
- R5: At most one flit leaves per cycle, across both outputs together.
- R6: When a response is waiting and its chosen output has response credit, the response leaves, even if a snoop is also ready.
- R7: When the waiting response is blocked for lack of credit, a ready snoop whose output has snoop credit leaves in that cycle.
- R8: A flit never leaves on an output whose credit counter for its class is zero. That counter drops by one for each flit sent and rises by one for each credit-return pulse. After `DN_CREDITS` sends with no return, the class stalls on that output, and it resumes in the cycle after a return.
- R9: In each cycle that a flit leaves, exactly one upstream credit bit pulses: the bit of that flit's class. In every other cycle no bit pulses.
- R10: Flits of one class leave in the order they arrived.
- R11: Each class buffers up to `BUF_DEPTH` flits while it is blocked. Buffered flits come out intact once credit returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A flit is present on the upstream link |
| in_vc | input | 1 | Class of the incoming flit (0 response, 1 snoop) |
| in_flit | input | DEST_W+PAY_W+2 | Incoming flit |
| up_credit | output | 2 | Credit pulse back to the upstream sender, one bit per class |
| loc_valid | output | 1 | Flit present on the local exit |
| loc_vc | output | 1 | Class of the local-exit flit |
| loc_flit | output | DEST_W+PAY_W+2 | Local-exit flit |
| loc_credit_in | input | 2 | Credit returns from the core, one bit per class |
| net_valid | output | 1 | Flit present on the network output |
| net_vc | output | 1 | Class of the network flit |
| net_flit | output | DEST_W+PAY_W+2 | Network-output flit |
| net_credit_in | input | 2 | Credit returns from the next node, one bit per class |

## Verification
The bound checker watches several properties on every cycle. It checks that only one output is valid at a time and that the upstream credit pulse matches the class that left. It checks that no flit arrives into a full class buffer. It checks response-first selection, and the snoop bypass when the response is blocked. Using its own credit ledger, it checks that no flit leaves on a class and output that has no credit left. Other properties need the bench's scenarios: the destination sweep for steering, packets whose middle and last flits carry misleading destinations, the one-cycle zero-load latency, ordering within a class, and a buffer that fills while blocked and then drains.

// File: rtl/dsn_pkg.sv
package dsn_pkg;

  localparam int NUM_CLS  = 2;
  localparam int NUM_PORT = 2;

  typedef enum logic { CLS_RESP = 1'b0, CLS_SNOOP = 1'b1 } cls_e;
  typedef enum logic { PORT_LOCAL = 1'b0, PORT_NET = 1'b1 } port_e;

  // static priority: response class beats snoop class
  function automatic logic [1:0] prio_grant(logic [1:0] req);
    if (req[CLS_RESP])       return 2'b01;
    else if (req[CLS_SNOOP]) return 2'b10;
    else                     return 2'b00;
  endfunction

  // flat index of a credit counter for (output, class)
  function automatic int cred_idx(int port, int cls);
    return port * NUM_CLS + cls;
  endfunction

endpackage

// File: rtl/dsn_vc_fifo.sv
module dsn_vc_fifo #(
  parameter int WIDTH = 13,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    fill;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign dout  = mem[rd_ptr];
  assign empty = (fill == '0);
  assign full  = (fill == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/dsn_credit_ctr.sv
module dsn_credit_ctr #(
  parameter int MAX_CRED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic avail
);
  localparam int CW = $clog2(MAX_CRED + 1);

  logic [CW-1:0] cnt;

  assign avail = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CW'(MAX_CRED);
    end else begin
      case ({take, give})
        2'b10:   cnt <= cnt - 1'b1;
        2'b01:   cnt <= cnt + 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dsn_vc_steer.sv
module dsn_vc_steer #(
  parameter int DEST_W  = 3,
  parameter int NODE_ID = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first,
  input  logic              last,
  input  logic [DEST_W-1:0] dest,
  input  logic              pop,
  output logic              to_local
);
  logic in_pkt;
  logic held_local;
  logic match;

  assign match    = (dest == DEST_W'(NODE_ID));
  assign to_local = (first || !in_pkt) ? match : held_local;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt     <= 1'b0;
      held_local <= 1'b0;
    end else if (pop) begin
      if (first || !in_pkt) held_local <= match;
      in_pkt <= !last;
    end
  end
endmodule

// File: rtl/dsn_split_node.sv
module dsn_split_node
  import dsn_pkg::*;
#(
  parameter int NODE_ID    = 5,
  parameter int DEST_W     = 3,
  parameter int PAY_W      = 8,
  parameter int BUF_DEPTH  = 2,
  parameter int DN_CREDITS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_vc,
  input  logic [DEST_W+PAY_W+1:0] in_flit,
  output logic [1:0]              up_credit,
  output logic                    loc_valid,
  output logic                    loc_vc,
  output logic [DEST_W+PAY_W+1:0] loc_flit,
  input  logic [1:0]              loc_credit_in,
  output logic                    net_valid,
  output logic                    net_vc,
  output logic [DEST_W+PAY_W+1:0] net_flit,
  input  logic [1:0]              net_credit_in
);
  localparam int FW     = DEST_W + PAY_W + 2;
  localparam int FIRST  = FW - 1;
  localparam int LAST   = FW - 2;
  localparam int NCRED  = NUM_PORT * NUM_CLS;

  function automatic logic [DEST_W-1:0] dest_of(logic [FW-1:0] f);
    return f[PAY_W +: DEST_W];
  endfunction

  logic [FW-1:0]    front [NUM_CLS];
  logic [1:0]       buf_empty, buf_full, push, grant, to_local, vc_req, cred_ok;
  logic [NCRED-1:0] cred_av, cred_take, cred_give;
  logic             win_cls, win_local, fire;

  // per-class buffering and steering
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    assign push[c] = in_valid && (in_vc == c[0]);

    dsn_vc_fifo #(.WIDTH(FW), .DEPTH(BUF_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push[c]),
      .din   (in_flit),
      .pop   (grant[c]),
      .dout  (front[c]),
      .empty (buf_empty[c]),
      .full  (buf_full[c])
    );

    dsn_vc_steer #(.DEST_W(DEST_W), .NODE_ID(NODE_ID)) u_steer (
      .clk      (clk),
      .rst_n    (rst_n),
      .first    (front[c][FIRST]),
      .last     (front[c][LAST]),
      .dest     (dest_of(front[c])),
      .pop      (grant[c]),
      .to_local (to_local[c])
    );

    assign cred_ok[c] = to_local[c] ? cred_av[cred_idx(PORT_LOCAL, c)]
                                    : cred_av[cred_idx(PORT_NET, c)];
    assign vc_req[c]  = !buf_empty[c] && cred_ok[c];
  end

  // downstream credits, one counter per output per class
  for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cc
      localparam int IX = p * NUM_CLS + c;
      assign cred_take[IX] = grant[c] && (to_local[c] == (p == 0));
      assign cred_give[IX] = (p == 0) ? loc_credit_in[c] : net_credit_in[c];

      dsn_credit_ctr #(.MAX_CRED(DN_CREDITS)) u_cred (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (cred_take[IX]),
        .give  (cred_give[IX]),
        .avail (cred_av[IX])
      );
    end
  end

  // selection and demux
  assign grant     = prio_grant(vc_req);
  assign fire      = |grant;
  assign win_cls   = grant[CLS_SNOOP];
  assign win_local = to_local[win_cls];

  assign loc_valid = fire && win_local;
  assign net_valid = fire && !win_local;
  assign loc_vc    = win_cls;
  assign net_vc    = win_cls;
  assign loc_flit  = front[win_cls];
  assign net_flit  = front[win_cls];
  assign up_credit = grant;

endmodule

// File: rtl/dsn_split_node_chk.sv
module dsn_split_node_chk #(
  parameter int DN_CREDITS = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_vc,
  input logic [1:0] buf_full,
  input logic [1:0] vc_req,
  input logic [1:0] up_credit,
  input logic       loc_valid,
  input logic       loc_vc,
  input logic [1:0] loc_credit_in,
  input logic       net_valid,
  input logic       net_vc,
  input logic [1:0] net_credit_in
);
  // independent credit ledger: 0 loc/resp, 1 loc/snoop, 2 net/resp, 3 net/snoop
  int         ledger [4];
  logic [3:0] snd, ret;

  always_comb begin
    snd[0] = loc_valid && !loc_vc;
    snd[1] = loc_valid &&  loc_vc;
    snd[2] = net_valid && !net_vc;
    snd[3] = net_valid &&  net_vc;
    ret    = {net_credit_in, loc_credit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) ledger[i] <= DN_CREDITS;
    end else begin
      for (int i = 0; i < 4; i++)
        ledger[i] <= ledger[i] - int'(snd[i]) + int'(ret[i]);
    end
  end

  a_r5_single_exit: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_valid && net_valid));

  a_r9_credit_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(up_credit) == ((loc_valid || net_valid) ? 1 : 0));

  a_r9_credit_class: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid || net_valid) |-> up_credit[loc_valid ? loc_vc : net_vc]);

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !buf_full[in_vc]);

  a_r6_resp_first: assert property (@(posedge clk) disable iff (!rst_n)
    vc_req[0] |-> ((loc_valid && !loc_vc) || (net_valid && !net_vc)));

  a_r7_snoop_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_req[1] && !vc_req[0]) |-> ((loc_valid && loc_vc) || (net_valid && net_vc)));

  a_r8_loc_credit: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid |-> (ledger[loc_vc ? 1 : 0] > 0));

  a_r8_net_credit: assert property (@(posedge clk) disable iff (!rst_n)
    net_valid |-> (ledger[net_vc ? 3 : 2] > 0));

endmodule

bind dsn_split_node dsn_split_node_chk #(.DN_CREDITS(DN_CREDITS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_vc         (in_vc),
  .buf_full      (buf_full),
  .vc_req        (vc_req),
  .up_credit     (up_credit),
  .loc_valid     (loc_valid),
  .loc_vc        (loc_vc),
  .loc_credit_in (loc_credit_in),
  .net_valid     (net_valid),
  .net_vc        (net_vc),
  .net_credit_in (net_credit_in)
);

// File: tb/sim_dsn_split_node.sv
module sim_dsn_split_node;
  localparam int NODE = 5;
  localparam int FW   = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_vc = 1'b0;
  logic [FW-1:0] in_flit = '0;
  logic [1:0]    up_credit;
  logic          loc_valid, loc_vc, net_valid, net_vc;
  logic [FW-1:0] loc_flit, net_flit;
  logic [1:0]    loc_credit_in = 2'b00;
  logic [1:0]    net_credit_in = 2'b00;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dsn_split_node #(.NODE_ID(NODE), .DEST_W(3), .PAY_W(8), .BUF_DEPTH(2), .DN_CREDITS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_flit(in_flit),
    .up_credit(up_credit),
    .loc_valid(loc_valid), .loc_vc(loc_vc), .loc_flit(loc_flit), .loc_credit_in(loc_credit_in),
    .net_valid(net_valid), .net_vc(net_vc), .net_flit(net_flit), .net_credit_in(net_credit_in)
  );

  function automatic logic [FW-1:0] mk(logic first, logic last, int dest, int pay);
    return {first, last, 3'(dest), 8'(pay)};
  endfunction

  // drive one cycle of inputs at a falling edge, then wait for the next falling edge
  task automatic step(logic v, logic vc, logic [FW-1:0] f, logic [1:0] lc, logic [1:0] nc);
    in_valid = v; in_vc = vc; in_flit = f;
    loc_credit_in = lc; net_credit_in = nc;
    @(negedge clk);
    in_valid = 1'b0; loc_credit_in = 2'b00; net_credit_in = 2'b00;
  endtask

  task automatic expect_out(string tag, logic e_loc, logic e_net, logic e_vc, logic [FW-1:0] e_f);
    logic          a_vc;
    logic [FW-1:0] a_f;
    logic [1:0]    e_cr;
    a_vc = loc_valid ? loc_vc : net_vc;
    a_f  = loc_valid ? loc_flit : net_flit;
    total++;
    if (loc_valid !== e_loc || net_valid !== e_net ||
        ((e_loc || e_net) && (a_vc !== e_vc || a_f !== e_f))) begin
      bad++;
      $display("FAIL %s: loc=%b net=%b vc=%b flit=%h, expected loc=%b net=%b vc=%b flit=%h",
               tag, loc_valid, net_valid, a_vc, a_f, e_loc, e_net, e_vc, e_f);
    end
    e_cr = (e_loc || e_net) ? (e_vc ? 2'b10 : 2'b01) : 2'b00;
    total++;
    if (up_credit !== e_cr) begin
      bad++;
      $display("FAIL R9 (%s): up_credit=%b, expected %b", tag, up_credit, e_cr);
    end
  endtask

  task automatic expect_idle(string tag);
    expect_out(tag, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_idle("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect_idle("R1 after reset");
  endtask

  initial begin
    logic [1:0] pl, pn;
    logic       loc;
    logic [FW-1:0] f;
    @(negedge clk);
    apply_reset();

    // R2 / R4: every destination on both classes, credit returned the next cycle
    pl = 2'b00; pn = 2'b00;
    for (int vc = 0; vc < 2; vc++) begin
      for (int d = 0; d < 8; d++) begin
        f   = mk(1'b1, 1'b1, d, vc * 16 + d + 8'h40);
        loc = (d == NODE);
        step(1'b1, vc[0], f, pl, pn);
        expect_out("R2 R4 dest sweep", loc, !loc, vc[0], f);
        pl = loc ? (vc[0] ? 2'b10 : 2'b01) : 2'b00;
        pn = loc ? 2'b00 : (vc[0] ? 2'b10 : 2'b01);
      end
    end
    step(1'b0, 1'b0, '0, pl, pn);
    expect_idle("R5 idle after sweep");

    // R3: later flits follow the first flit, not their own destination
    step(1'b1, 1'b0, mk(1, 0, NODE, 8'h11), 2'b00, 2'b00);
    expect_out("R3 head local", 1, 0, 0, mk(1, 0, NODE, 8'h11));
    step(1'b1, 1'b0, mk(0, 0, 2, 8'h12), 2'b01, 2'b00);
    expect_out("R3 body local", 1, 0, 0, mk(0, 0, 2, 8'h12));
    step(1'b1, 1'b0, mk(0, 1, 2, 8'h13), 2'b01, 2'b00);
    expect_out("R3 tail local", 1, 0, 0, mk(0, 1, 2, 8'h13));
    step(1'b1, 1'b1, mk(1, 0, 1, 8'h21), 2'b01, 2'b00);
    expect_out("R3 head net", 0, 1, 1, mk(1, 0, 1, 8'h21));
    step(1'b1, 1'b1, mk(0, 0, NODE, 8'h22), 2'b00, 2'b10);
    expect_out("R3 body net", 0, 1, 1, mk(0, 0, NODE, 8'h22));
    step(1'b1, 1'b1, mk(0, 1, NODE, 8'h23), 2'b00, 2'b10);
    expect_out("R3 tail net", 0, 1, 1, mk(0, 1, NODE, 8'h23));
    step(1'b0, 1'b0, '0, 2'b00, 2'b10);
    expect_idle("R3 drained");

    // R8: credit exhaustion on network/response, then resume
    apply_reset();
    step(1'b1, 1'b0, mk(1, 1, 1, 8'hA1), 2'b00, 2'b00);
    expect_out("R8 first send", 0, 1, 0, mk(1, 1, 1, 8'hA1));
    step(1'b1, 1'b0, mk(1, 1, 1, 8'hA2), 2'b00, 2'b00);
    expect_out("R8 second send", 0, 1, 0, mk(1, 1, 1, 8'hA2));
    step(1'b1, 1'b0, mk(1, 1, 1, 8'hA3), 2'b00, 2'b00);
    expect_idle("R8 stalled at zero credit");
    step(1'b0, 1'b0, '0, 2'b00, 2'b01);
    expect_out("R8 resumes after return", 0, 1, 0, mk(1, 1, 1, 8'hA3));
    step(1'b0, 1'b0, '0, 2'b00, 2'b00);
    expect_idle("R8 idle");

    // R7: blocked response lets snoops through
    step(1'b1, 1'b0, mk(1, 1, 1, 8'hA4), 2'b00, 2'b00);
    expect_idle("R7 response blocked");
    step(1'b1, 1'b1, mk(1, 1, 1, 8'hB1), 2'b00, 2'b00);
    expect_out("R7 snoop bypass", 0, 1, 1, mk(1, 1, 1, 8'hB1));
    step(1'b1, 1'b1, mk(1, 1, 1, 8'hB2), 2'b00, 2'b00);
    expect_out("R7 snoop bypass 2", 0, 1, 1, mk(1, 1, 1, 8'hB2));
    step(1'b1, 1'b1, mk(1, 1, 1, 8'hB3), 2'b00, 2'b00);
    expect_idle("R8 both classes blocked");

    // R6: both get credit in the same cycle, response wins
    step(1'b0, 1'b0, '0, 2'b00, 2'b11);
    expect_out("R6 response first", 0, 1, 0, mk(1, 1, 1, 8'hA4));
    step(1'b0, 1'b0, '0, 2'b00, 2'b00);
    expect_out("R6 snoop next", 0, 1, 1, mk(1, 1, 1, 8'hB3));
    step(1'b0, 1'b0, '0, 2'b00, 2'b00);
    expect_idle("R6 drained");

    // R10 / R11: fill the local response buffer while blocked, then drain in order
    step(1'b1, 1'b0, mk(1, 1, NODE, 8'hC1), 2'b00, 2'b00);
    expect_out("R11 local send 1", 1, 0, 0, mk(1, 1, NODE, 8'hC1));
    step(1'b1, 1'b0, mk(1, 1, NODE, 8'hC2), 2'b00, 2'b00);
    expect_out("R11 local send 2", 1, 0, 0, mk(1, 1, NODE, 8'hC2));
    step(1'b1, 1'b0, mk(1, 1, NODE, 8'hC3), 2'b00, 2'b00);
    expect_idle("R11 buffered 1");
    step(1'b1, 1'b0, mk(1, 1, NODE, 8'hC4), 2'b00, 2'b00);
    expect_idle("R11 buffered 2");
    step(1'b0, 1'b0, '0, 2'b01, 2'b00);
    expect_out("R10 R11 drain first", 1, 0, 0, mk(1, 1, NODE, 8'hC3));
    step(1'b0, 1'b0, '0, 2'b01, 2'b00);
    expect_out("R10 R11 drain second", 1, 0, 0, mk(1, 1, NODE, 8'hC4));
    step(1'b0, 1'b0, '0, 2'b00, 2'b00);
    expect_idle("R11 empty");

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule